// File: doc/BRIEF.md
# Command-List Sequencer

The sequencer walks a list of 32-bit command words held in memory and turns each command into an action on one of its output ports. Software loads a list, places its byte address on the base input and pulses start. The block then fetches words one at a time through a synchronous read port with a response handshake. It assembles each command from one to four words and executes it. The opcode sits in the top nibble of the first word, and that nibble alone fixes how many words the command spans.

There are four kinds of action. A transfer command hands a destination address, a byte count and line start/end markers to a separate data mover over a valid/ready handshake. A masked register-write command drives a write port with an address, a value and a bit mask. A jump redirects the fetch pointer. A line-sync command parks the sequencer until the video timing reports a chosen line number.

Every command can also carry four side flags: increment the completion counter, clear it, and raise either of two interrupt pulses. A comparator reports whether a buffer tagged with a given count has finished, and the comparison stays correct when the 16-bit counter wraps. An opcode the block does not know, or a failed memory read, halts the block with a sticky error flag.

Top module: `cmd_seq`

## Requirements
- R1: After reset the block is idle: busy_o, error_o, mem_req_o, xfer_valid_o, reg_we_o, irq1_o and irq2_o are 0, and count_o is 0.
- R2: The transfer opcode is 0x1 (bits 31:28). It raises xfer_valid_o with xfer_addr_o set to the second word and xfer_len_o set to bits 11:0 of the first word. xfer_sol_o is bit 27 and xfer_eol_o is bit 26 of the first word. All four stay stable until xfer_ready_i is seen high.
- R3: Command length depends only on the opcode. Transfer (0x1) and jump (0x7) take 2 words. Opcodes 0xB and 0xC take 3 words and cause no port action. Masked write (0x9) takes 4 words. Line sync (0x8) takes 1 word. The next command is fetched from the word that follows, and one read is outstanding at a time.
- R4: A jump command makes its second word the byte address of the next fetch.
- R5: The masked-write command pulses reg_we_o for one cycle. reg_addr_o is the second word, reg_wdata_o the third and reg_mask_o the fourth.
- R6: A line-sync command with bit 15 set waits until sync_valid_i is high with sync_line_i equal to bits 11:0 of the command. With bit 15 clear it completes at once.
- R7: Bit 16 of a finished command increments count_o, modulo 2^16. Bit 17 clears it to 0, and clearing wins when both bits are set.
- R8: tag_done_o is 1 exactly when count_o minus tag_i, taken as a signed 16-bit value, is not negative.
- R9: Bit 24 (irq1_o) and bit 25 (irq2_o) of a command each give a one-cycle pulse in the cycle after the command finishes.
- R10: An opcode other than 0x1, 0x7, 0x8, 0x9, 0xB or 0xC, or mem_err_i on a read response, stops all fetching and sets error_o. error_o stays set until start_i or stop_i is pulsed.
- R11: stop_i returns the block to idle and drops any pending transfer request. start_i restarts fetching at base_addr_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin fetching at base_addr_i |
| stop_i | input | 1 | Abort and go idle |
| base_addr_i | input | AW | Byte address of the first command |
| busy_o | output | 1 | Fetching or executing |
| error_o | output | 1 | Sticky halt-on-error flag |
| mem_req_o | output | 1 | Read request, one cycle per word |
| mem_addr_o | output | AW | Read byte address |
| mem_rvalid_i | input | 1 | Read response valid |
| mem_rdata_i | input | 32 | Read response word |
| mem_err_i | input | 1 | Read response failed |
| xfer_valid_o | output | 1 | Transfer request |
| xfer_ready_i | input | 1 | Data mover accepts request |
| xfer_addr_o | output | 32 | Destination byte address |
| xfer_len_o | output | 12 | Byte count |
| xfer_sol_o | output | 1 | First piece of a line |
| xfer_eol_o | output | 1 | Last piece of a line |
| reg_we_o | output | 1 | Register write strobe |
| reg_addr_o | output | 32 | Register address |
| reg_wdata_o | output | 32 | Register value |
| reg_mask_o | output | 32 | Bits of the register to update |
| irq1_o | output | 1 | Interrupt pulse 1 |
| irq2_o | output | 1 | Interrupt pulse 2 |
| sync_valid_i | input | 1 | Line event strobe |
| sync_line_i | input | LW | Current line number |
| count_o | output | CW | Completion counter |
| tag_i | input | CW | Buffer tag to compare |
| tag_done_o | output | 1 | Tagged buffer is complete |

## Verification
One list splits a scanline across three transfers and follows it with a whole line. The marker outputs must then show start-only, neither, end-only and both, which separates the two flag bits from each other and from the count field. A list that mixes 3-word no-op commands, a non-waiting sync and a masked write ahead of a transfer detects any wrong length, because a misaligned fetch lands on a zero word and halts. Tags on either side of the counter and across the half-range wrap tell a signed comparison apart from an unsigned one. A sync held on a wrong line, and reads that fail in mid-command, show that stalls and halts block all later traffic.

// File: rtl/cmd_seq_pkg.sv
package cmd_seq_pkg;
  localparam int unsigned WORD_W  = 32;
  localparam int unsigned MAX_LEN = 4;
  localparam int unsigned LEN_W   = $clog2(MAX_LEN + 1);
  localparam int unsigned IDX_W   = $clog2(MAX_LEN);
  localparam int unsigned CNT_W   = 12;

  localparam logic [3:0] OP_WRITE   = 4'h1;
  localparam logic [3:0] OP_JUMP    = 4'h7;
  localparam logic [3:0] OP_SYNC    = 4'h8;
  localparam logic [3:0] OP_WRITECR = 4'h9;
  localparam logic [3:0] OP_SKIP3A  = 4'hB;
  localparam logic [3:0] OP_SKIP3B  = 4'hC;

  localparam int unsigned B_RESYNC = 15;
  localparam int unsigned B_INC    = 16;
  localparam int unsigned B_CLR    = 17;
  localparam int unsigned B_IRQ1   = 24;
  localparam int unsigned B_IRQ2   = 25;
  localparam int unsigned B_EOL    = 26;
  localparam int unsigned B_SOL    = 27;

  typedef struct packed {
    logic             sol;
    logic             eol;
    logic             irq2;
    logic             irq1;
    logic             cnt_clr;
    logic             cnt_inc;
    logic             resync;
    logic [CNT_W-1:0] cnt;
  } cmd_flags_t;

  typedef enum logic [2:0] {
    S_IDLE, S_REQ, S_WAIT, S_EXEC, S_XFER, S_REG, S_SYNC, S_HALT
  } seq_state_e;
endpackage

// File: rtl/cmd_seq_decode.sv
module cmd_seq_decode
  import cmd_seq_pkg::*;
(
  input  logic [WORD_W-1:0] word_i,
  output logic [3:0]        op_o,
  output logic [LEN_W-1:0]  len_o,
  output logic              legal_o,
  output cmd_flags_t        flags_o
);
  assign op_o = word_i[WORD_W-1 -: 4];

  always_comb begin
    legal_o = 1'b1;
    unique case (op_o)
      OP_WRITE, OP_JUMP:    len_o = LEN_W'(2);
      OP_SKIP3A, OP_SKIP3B: len_o = LEN_W'(3);
      OP_WRITECR:           len_o = LEN_W'(4);
      OP_SYNC:              len_o = LEN_W'(1);
      default: begin
        len_o   = LEN_W'(1);
        legal_o = 1'b0;
      end
    endcase
  end

  assign flags_o.sol     = word_i[B_SOL];
  assign flags_o.eol     = word_i[B_EOL];
  assign flags_o.irq2    = word_i[B_IRQ2];
  assign flags_o.irq1    = word_i[B_IRQ1];
  assign flags_o.cnt_clr = word_i[B_CLR];
  assign flags_o.cnt_inc = word_i[B_INC];
  assign flags_o.resync  = word_i[B_RESYNC];
  assign flags_o.cnt     = word_i[CNT_W-1:0];
endmodule

// File: rtl/cmd_seq_ctr.sv
module cmd_seq_ctr #(
  parameter int unsigned CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          inc_i,
  input  logic          clr_i,
  input  logic [CW-1:0] tag_i,
  output logic [CW-1:0] count_o,
  output logic          tag_done_o
);
  logic [CW-1:0] count_q;
  logic [CW-1:0] diff;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    count_q <= '0;
    else if (clr_i) count_q <= '0;
    else if (inc_i) count_q <= count_q + CW'(1);
  end

  // wrap-safe: sign of the modular difference
  assign diff       = count_q - tag_i;
  assign tag_done_o = ~diff[CW-1];
  assign count_o    = count_q;
endmodule

// File: rtl/cmd_seq_pulse.sv
module cmd_seq_pulse #(
  parameter int unsigned N = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         fire_i,
  input  logic [N-1:0] req_i,
  output logic [N-1:0] pulse_o
);
  for (genvar i = 0; i < N; i++) begin : g_line
    logic p_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) p_q <= 1'b0;
      else         p_q <= fire_i & req_i[i];
    end
    assign pulse_o[i] = p_q;
  end
endmodule

// File: rtl/cmd_seq.sv
module cmd_seq
  import cmd_seq_pkg::*;
#(
  parameter int unsigned AW = 32,
  parameter int unsigned CW = 16,
  parameter int unsigned LW = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic [AW-1:0]     base_addr_i,
  output logic              busy_o,
  output logic              error_o,
  output logic              mem_req_o,
  output logic [AW-1:0]     mem_addr_o,
  input  logic              mem_rvalid_i,
  input  logic [WORD_W-1:0] mem_rdata_i,
  input  logic              mem_err_i,
  output logic              xfer_valid_o,
  input  logic              xfer_ready_i,
  output logic [WORD_W-1:0] xfer_addr_o,
  output logic [CNT_W-1:0]  xfer_len_o,
  output logic              xfer_sol_o,
  output logic              xfer_eol_o,
  output logic              reg_we_o,
  output logic [WORD_W-1:0] reg_addr_o,
  output logic [WORD_W-1:0] reg_wdata_o,
  output logic [WORD_W-1:0] reg_mask_o,
  output logic              irq1_o,
  output logic              irq2_o,
  input  logic              sync_valid_i,
  input  logic [LW-1:0]     sync_line_i,
  output logic [CW-1:0]     count_o,
  input  logic [CW-1:0]     tag_i,
  output logic              tag_done_o
);
  localparam logic [AW-1:0] WORD_STEP = AW'(WORD_W / 8);

  seq_state_e        state_q, state_d;
  logic [AW-1:0]     pc_q, pc_d;
  logic [IDX_W-1:0]  widx_q, widx_d;
  logic              err_q, err_d;
  logic [WORD_W-1:0] w_q [MAX_LEN];
  logic              w_we;
  logic              cmd_done;

  logic [3:0]        rd_op, cur_op;
  logic [LEN_W-1:0]  rd_len, cur_len;
  logic              rd_legal, cur_legal;
  cmd_flags_t        rd_flags, cur_flags;
  logic              last_word;
  logic              line_hit;

  cmd_seq_decode u_dec_rd (
    .word_i (mem_rdata_i),
    .op_o   (rd_op),
    .len_o  (rd_len),
    .legal_o(rd_legal),
    .flags_o(rd_flags)
  );

  cmd_seq_decode u_dec_cur (
    .word_i (w_q[0]),
    .op_o   (cur_op),
    .len_o  (cur_len),
    .legal_o(cur_legal),
    .flags_o(cur_flags)
  );

  assign last_word = (widx_q == '0) ? (rd_len == LEN_W'(1))
                                    : (LEN_W'(widx_q) == cur_len - LEN_W'(1));
  assign line_hit  = sync_valid_i && (sync_line_i == w_q[0][LW-1:0]);

  always_comb begin
    state_d  = state_q;
    pc_d     = pc_q;
    widx_d   = widx_q;
    err_d    = err_q;
    w_we     = 1'b0;
    cmd_done = 1'b0;
    unique case (state_q)
      S_REQ: state_d = S_WAIT;
      S_WAIT: begin
        if (mem_rvalid_i) begin
          pc_d = pc_q + WORD_STEP;
          if (mem_err_i || (widx_q == '0 && !rd_legal)) begin
            state_d = S_HALT;
            err_d   = 1'b1;
          end else begin
            w_we = 1'b1;
            if (last_word) begin
              state_d = S_EXEC;
            end else begin
              widx_d  = widx_q + IDX_W'(1);
              state_d = S_REQ;
            end
          end
        end
      end
      S_EXEC: begin
        unique case (cur_op)
          OP_WRITE:   state_d = S_XFER;
          OP_WRITECR: state_d = S_REG;
          OP_SYNC: begin
            if (cur_flags.resync) state_d = S_SYNC;
            else                  cmd_done = 1'b1;
          end
          default:    cmd_done = 1'b1;
        endcase
      end
      S_XFER: cmd_done = xfer_ready_i;
      S_REG:  cmd_done = 1'b1;
      S_SYNC: cmd_done = line_hit;
      default: ;
    endcase
    if (cmd_done) begin
      state_d = S_REQ;
      widx_d  = '0;
      if (cur_op == OP_JUMP) pc_d = w_q[1][AW-1:0];
    end
    if (start_i) begin
      state_d = S_REQ;
      pc_d    = base_addr_i;
      widx_d  = '0;
      err_d   = 1'b0;
    end
    if (stop_i) begin
      state_d = S_IDLE;
      widx_d  = '0;
      err_d   = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      pc_q    <= '0;
      widx_q  <= '0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      pc_q    <= pc_d;
      widx_q  <= widx_d;
      err_q   <= err_d;
    end
  end

  for (genvar i = 0; i < MAX_LEN; i++) begin : g_word
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                w_q[i] <= '0;
      else if (w_we && widx_q == IDX_W'(i))       w_q[i] <= mem_rdata_i;
    end
  end

  cmd_seq_ctr #(.CW(CW)) u_ctr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .inc_i     (cmd_done & cur_flags.cnt_inc),
    .clr_i     (cmd_done & cur_flags.cnt_clr),
    .tag_i     (tag_i),
    .count_o   (count_o),
    .tag_done_o(tag_done_o)
  );

  logic [1:0] irq_req, irq_pulse;
  assign irq_req = {cur_flags.irq2, cur_flags.irq1};

  cmd_seq_pulse #(.N(2)) u_irq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .fire_i (cmd_done),
    .req_i  (irq_req),
    .pulse_o(irq_pulse)
  );

  assign irq1_o       = irq_pulse[0];
  assign irq2_o       = irq_pulse[1];
  assign busy_o       = (state_q != S_IDLE) && (state_q != S_HALT);
  assign error_o      = err_q;
  assign mem_req_o    = (state_q == S_REQ);
  assign mem_addr_o   = pc_q;
  assign xfer_valid_o = (state_q == S_XFER);
  assign xfer_addr_o  = w_q[1];
  assign xfer_len_o   = cur_flags.cnt;
  assign xfer_sol_o   = cur_flags.sol;
  assign xfer_eol_o   = cur_flags.eol;
  assign reg_we_o     = (state_q == S_REG);
  assign reg_addr_o   = w_q[1];
  assign reg_wdata_o  = w_q[2];
  assign reg_mask_o   = w_q[3];

  logic unused_ok;
  assign unused_ok = &{1'b0, rd_flags, cur_legal};
endmodule

// File: rtl/cmd_seq_chk.sv
module cmd_seq_chk #(
  parameter int unsigned AW = 32,
  parameter int unsigned CW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          start_i,
  input logic          stop_i,
  input logic          mem_req_o,
  input logic          xfer_valid_o,
  input logic          xfer_ready_i,
  input logic [31:0]   xfer_addr_o,
  input logic [11:0]   xfer_len_o,
  input logic          reg_we_o,
  input logic          irq1_o,
  input logic          irq2_o,
  input logic          error_o,
  input logic [CW-1:0] count_o
);
  // R2
  xfer_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_valid_o && !xfer_ready_i && !start_i && !stop_i
    |=> xfer_valid_o && $stable(xfer_addr_o) && $stable(xfer_len_o));

  // R3
  one_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |=> !mem_req_o);

  // R5
  reg_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_o |=> !reg_we_o);

  // R7
  count_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(count_o) |-> (count_o == $past(count_o) + CW'(1)) || (count_o == '0));

  // R9
  irq1_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq1_o |=> !irq1_o);

  // R9
  irq2_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq2_o |=> !irq2_o);

  // R10
  halt_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    error_o |-> !mem_req_o && !xfer_valid_o && !reg_we_o);
endmodule

bind cmd_seq cmd_seq_chk #(.AW(AW), .CW(CW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .stop_i      (stop_i),
  .mem_req_o   (mem_req_o),
  .xfer_valid_o(xfer_valid_o),
  .xfer_ready_i(xfer_ready_i),
  .xfer_addr_o (xfer_addr_o),
  .xfer_len_o  (xfer_len_o),
  .reg_we_o    (reg_we_o),
  .irq1_o      (irq1_o),
  .irq2_o      (irq2_o),
  .error_o     (error_o),
  .count_o     (count_o)
);

// File: tb/sim_cmd_seq.sv
`timescale 1ns/1ps
module sim_cmd_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0, stop = 1'b0;
  logic [31:0] base = '0;
  logic        busy, err;
  logic        mreq;
  logic [31:0] maddr;
  logic        mrvalid = 1'b0;
  logic [31:0] mrdata = '0;
  logic        merr = 1'b0;
  logic        xv, xrdy = 1'b1;
  logic [31:0] xaddr;
  logic [11:0] xlen;
  logic        xsol, xeol;
  logic        rwe;
  logic [31:0] raddr, rwdata, rmask;
  logic        irq1, irq2;
  logic        svalid = 1'b0;
  logic [11:0] sline = '0;
  logic [15:0] count;
  logic [15:0] tag = '0;
  logic        tdone;

  always #10 clk = ~clk;

  cmd_seq u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .stop_i(stop),
    .base_addr_i(base), .busy_o(busy), .error_o(err),
    .mem_req_o(mreq), .mem_addr_o(maddr), .mem_rvalid_i(mrvalid),
    .mem_rdata_i(mrdata), .mem_err_i(merr),
    .xfer_valid_o(xv), .xfer_ready_i(xrdy), .xfer_addr_o(xaddr),
    .xfer_len_o(xlen), .xfer_sol_o(xsol), .xfer_eol_o(xeol),
    .reg_we_o(rwe), .reg_addr_o(raddr), .reg_wdata_o(rwdata), .reg_mask_o(rmask),
    .irq1_o(irq1), .irq2_o(irq2), .sync_valid_i(svalid), .sync_line_i(sline),
    .count_o(count), .tag_i(tag), .tag_done_o(tdone)
  );

  // memory model: one-cycle read latency
  logic [31:0] mem [64];
  logic [31:0] err_addr = 32'hFFFF_FFFF;
  always @(posedge clk) begin
    mrvalid <= mreq;
    mrdata  <= mem[maddr[7:2]];
    merr    <= mreq && (maddr == err_addr);
  end

  // monitor
  int          cyc = 0, nx = 0, nreg = 0, nreq = 0, ni1 = 0, ni2 = 0, i1_cyc = 0, i2_cyc = 0;
  logic [31:0] lx_addr [16];
  logic [11:0] lx_len [16];
  logic [1:0]  lx_mk [16];
  int          lx_cyc [16];
  logic [31:0] lr_addr, lr_data, lr_mask;
  always @(posedge clk) begin
    cyc++;
    if (mreq) nreq++;
    if (xv && xrdy && nx < 16) begin
      lx_addr[nx] = xaddr; lx_len[nx] = xlen; lx_mk[nx] = {xsol, xeol}; lx_cyc[nx] = cyc;
      nx++;
    end
    if (rwe) begin
      lr_addr = raddr; lr_data = rwdata; lr_mask = rmask; nreg++;
    end
    if (irq1) begin ni1++; i1_cyc = cyc; end
    if (irq2) begin ni2++; i2_cyc = cyc; end
  end

  int nchk = 0, nfail = 0;
  bit finished = 1'b0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input logic [3:0] op, input logic sol, eol, i1, i2,
                                     inc, clr, rs, input logic [11:0] n);
    return {op, sol, eol, i2, i1, 6'd0, clr, inc, rs, 3'd0, n};
  endfunction

  localparam logic [31:0] PARK = {4'h8, 12'd0, 1'b1, 3'd0, 12'hFFF};

  task automatic clear_mem();
    for (int i = 0; i < 64; i++) mem[i] = '0;
  endtask

  task automatic clear_logs();
    nx = 0; nreg = 0; ni1 = 0; ni2 = 0; nreq = 0;
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic run(input logic [31:0] b, input int n);
    @(negedge clk);
    clear_logs();
    base = b; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cycles(n);
  endtask

  task automatic t_reset();
    chk("R1 busy", {31'd0, busy}, 32'd0);
    chk("R1 error", {31'd0, err}, 32'd0);
    chk("R1 idle outputs", {27'd0, mreq, xv, rwe, irq1, irq2}, 32'd0);
    chk("R1 count", {16'd0, count}, 32'd0);
  endtask

  task automatic t_write_marks();
    clear_mem();
    mem[0] = mk(4'h1, 1, 0, 0, 0, 0, 0, 0, 12'd100);  mem[1] = 32'h0000_1000;
    mem[2] = mk(4'h1, 0, 0, 0, 0, 0, 0, 0, 12'd200);  mem[3] = 32'h0000_2000;
    mem[4] = mk(4'h1, 0, 1, 0, 0, 0, 0, 0, 12'd50);   mem[5] = 32'h0000_3000;
    mem[6] = mk(4'h1, 1, 1, 0, 0, 0, 0, 0, 12'd720);  mem[7] = 32'h0000_4000;
    mem[8] = PARK;
    run(32'h0, 120);
    chk("R2 transfer count", nx, 4);
    chk("R2 split first", {lx_addr[0][15:0], 2'b0, lx_mk[0], lx_len[0]}, {16'h1000, 4'b0010, 12'd100});
    chk("R2 split middle", {lx_addr[1][15:0], 2'b0, lx_mk[1], lx_len[1]}, {16'h2000, 4'b0000, 12'd200});
    chk("R2 split last", {lx_addr[2][15:0], 2'b0, lx_mk[2], lx_len[2]}, {16'h3000, 4'b0001, 12'd50});
    chk("R2 whole line", {lx_addr[3][15:0], 2'b0, lx_mk[3], lx_len[3]}, {16'h4000, 4'b0011, 12'd720});
  endtask

  task automatic t_stall();
    clear_mem();
    mem[0] = mk(4'h1, 1, 1, 0, 0, 0, 0, 0, 12'd16); mem[1] = 32'h0000_1234;
    mem[2] = PARK;
    xrdy = 1'b0;
    run(32'h0, 10);
    chk("R2 valid while stalled", {31'd0, xv}, 32'd1);
    cycles(5);
    chk("R2 held addr", xaddr, 32'h1234);
    chk("R2 held len", {20'd0, xlen}, 32'd16);
    chk("R2 no accept while not ready", nx, 0);
    xrdy = 1'b1;
    cycles(5);
    chk("R2 accepted once", nx, 1);
  endtask

  task automatic t_lengths();
    clear_mem();
    mem[0] = {4'hB, 28'd0}; mem[1] = 32'h0; mem[2] = 32'h0;
    mem[3] = {4'hC, 28'd0}; mem[4] = 32'h0; mem[5] = 32'h0;
    mem[6] = mk(4'h8, 0, 0, 0, 0, 0, 0, 0, 12'h123);
    mem[7] = mk(4'h9, 0, 0, 0, 0, 0, 0, 0, 12'd0);
    mem[8] = 32'h0000_0040; mem[9] = 32'hA5A5_0000; mem[10] = 32'hFFFF_0000;
    mem[11] = mk(4'h1, 1, 1, 0, 0, 0, 0, 0, 12'd8); mem[12] = 32'h0000_5000;
    mem[13] = PARK;
    run(32'h0, 150);
    chk("R3 no error after mixed lengths", {31'd0, err}, 32'd0);
    chk("R3 transfer after mixed lengths", nx, 1);
    chk("R3 transfer addr", lx_addr[0], 32'h5000);
    chk("R5 one reg write", nreg, 1);
    chk("R5 reg addr", lr_addr, 32'h40);
    chk("R5 reg value", lr_data, 32'hA5A5_0000);
    chk("R5 reg mask", lr_mask, 32'hFFFF_0000);
  endtask

  task automatic t_jump();
    clear_mem();
    mem[0] = mk(4'h7, 0, 0, 0, 0, 0, 0, 0, 12'd0); mem[1] = 32'h0000_0080;
    mem[2] = mk(4'h1, 1, 1, 0, 0, 0, 0, 0, 12'd4); mem[3] = 32'h0000_0BAD;
    mem[32] = mk(4'h1, 1, 1, 0, 0, 0, 0, 0, 12'd4); mem[33] = 32'h0000_6000;
    mem[34] = PARK;
    run(32'h0, 60);
    chk("R4 one transfer", nx, 1);
    chk("R4 jump target", lx_addr[0], 32'h6000);
  endtask

  task automatic t_sync();
    clear_mem();
    mem[0] = mk(4'h8, 0, 0, 0, 0, 0, 0, 1, 12'h200);
    mem[1] = mk(4'h1, 1, 1, 0, 0, 0, 0, 0, 12'd4); mem[2] = 32'h0000_7000;
    mem[3] = PARK;
    run(32'h0, 10);
    svalid = 1'b1; sline = 12'h100;
    cycles(10);
    svalid = 1'b0;
    chk("R6 waits on wrong line", nx, 0);
    chk("R6 still busy", {31'd0, busy}, 32'd1);
    sline = 12'h200;
    cycles(5);
    chk("R6 line without strobe ignored", nx, 0);
    svalid = 1'b1;
    @(negedge clk);
    svalid = 1'b0;
    cycles(15);
    chk("R6 proceeds on match", nx, 1);
    chk("R6 transfer addr", lx_addr[0], 32'h7000);
  endtask

  task automatic t_count();
    clear_mem();
    mem[0] = mk(4'h8, 0, 0, 0, 0, 0, 1, 0, 12'd0);
    mem[1] = mk(4'h8, 0, 0, 0, 0, 1, 0, 0, 12'd0);
    mem[2] = mk(4'h8, 0, 0, 0, 0, 1, 0, 0, 12'd0);
    mem[3] = mk(4'h8, 0, 0, 0, 0, 1, 0, 0, 12'd0);
    mem[4] = PARK;
    run(32'h0, 60);
    chk("R7 three increments", {16'd0, count}, 32'd3);
    tag = 16'd3;     #1 chk("R8 tag equal done", {31'd0, tdone}, 32'd1);
    tag = 16'd4;     #1 chk("R8 tag ahead not done", {31'd0, tdone}, 32'd0);
    tag = 16'h8003;  #1 chk("R8 half range not done", {31'd0, tdone}, 32'd0);
    tag = 16'h8004;  #1 chk("R8 wrapped tag done", {31'd0, tdone}, 32'd1);
    tag = 16'hFFFE;  #1 chk("R8 pre-wrap tag done", {31'd0, tdone}, 32'd1);
    clear_mem();
    mem[0] = mk(4'h8, 0, 0, 0, 0, 1, 1, 0, 12'd0);
    mem[1] = PARK;
    run(32'h0, 30);
    chk("R7 clear wins", {16'd0, count}, 32'd0);
  endtask

  task automatic t_irq();
    clear_mem();
    mem[0] = mk(4'h1, 1, 1, 1, 0, 0, 0, 0, 12'd4); mem[1] = 32'h0000_0100;
    mem[2] = mk(4'h1, 1, 1, 0, 1, 0, 0, 0, 12'd4); mem[3] = 32'h0000_0200;
    mem[4] = PARK;
    run(32'h0, 60);
    chk("R9 irq1 pulses", ni1, 1);
    chk("R9 irq2 pulses", ni2, 1);
    chk("R9 irq1 cycle after done", i1_cyc, lx_cyc[0] + 1);
    chk("R9 irq2 cycle after done", i2_cyc, lx_cyc[1] + 1);
  endtask

  task automatic t_error();
    int snap;
    clear_mem();
    mem[0] = 32'h2000_0000;
    run(32'h0, 10);
    chk("R10 bad opcode error", {31'd0, err}, 32'd1);
    chk("R10 bad opcode halts", {31'd0, busy}, 32'd0);
    snap = nreq;
    cycles(10);
    chk("R10 no fetch after halt", nreq, snap);
    mem[0] = mk(4'h1, 1, 1, 0, 0, 0, 0, 0, 12'd4); mem[1] = 32'h0000_0300;
    mem[2] = PARK;
    run(32'h0, 30);
    chk("R10 start clears error", {31'd0, err}, 32'd0);
    chk("R10 restart runs", nx, 1);
    err_addr = 32'h4;
    run(32'h0, 30);
    chk("R10 read error flag", {31'd0, err}, 32'd1);
    chk("R10 read error blocks transfer", nx, 0);
    err_addr = 32'hFFFF_FFFF;
    @(negedge clk); stop = 1'b1; @(negedge clk); stop = 1'b0;
    chk("R10 stop clears error", {31'd0, err}, 32'd0);
  endtask

  task automatic t_stop_base();
    clear_mem();
    mem[16] = mk(4'h1, 1, 1, 0, 0, 0, 0, 0, 12'd4); mem[17] = 32'h0000_9000;
    mem[18] = PARK;
    xrdy = 1'b0;
    run(32'h40, 15);
    chk("R11 base addr transfer pending", {xaddr[15:0], 15'd0, xv}, {16'h9000, 16'd1});
    stop = 1'b1; @(negedge clk); stop = 1'b0;
    chk("R11 stop idles", {30'd0, busy, xv}, 32'd0);
    xrdy = 1'b1;
    cycles(5);
    chk("R11 dropped request", nx, 0);
  endtask

  initial begin
    cycles(3);
    t_reset();
    rst_n = 1'b1;
    cycles(2);
    t_reset();
    t_write_marks();
    t_stall();
    t_lengths();
    t_jump();
    t_sync();
    t_count();
    t_irq();
    t_error();
    t_stop_base();
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nchk++; nfail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end
endmodule